// File: doc/BRIEF.md
# ADC Conversion Queue Sequencer

This block runs two queues of conversion commands held in a 64-entry command table. Each entry carries a 6-bit channel number and a pause bit. The block reads the table through a combinational read port. Queue one always begins at entry 0. Queue two begins at a 7-bit programmable start index. A trigger makes the chosen queue walk its entries in order. For each ordinary entry the block asks an external converter for one conversion and waits for its done pulse.

A queue can stop in two ways. A pause bit suspends it after that entry's conversion, and the next trigger resumes it at the following entry. An end-of-queue condition finishes it. There are three end-of-queue sources: the reserved channel code 63, running off the end of the table, and, for queue one only, reaching the queue two start index. Fixed precedence rules settle the cases where a pause and an end of queue fall together.

The block keeps sticky pause and completion flags for each queue, cleared by write-one-to-clear. Each interrupt output is its flag gated by an enable. A status output for each queue shows idle, active or paused.

Top module: `qseq_top`

## Requirements
- R1: After reset both statuses read idle (status code 0), all flags and interrupts are 0 and no conversion request is raised.
- R2: A triggered idle queue converts its entries in ascending order from its first entry, queue one from 0 and queue two from the start index. Only one request is outstanding at a time, and channel and request hold until the done pulse, which advances the entry index.
- R3: An entry holding channel code 63 ends the queue without a conversion. The completion flag is set and the status returns to idle, including when that entry is the first one read.
- R4: Queue one ends when its index reaches the queue two start index. With a start index of 0, a queue one trigger completes with no conversion.
- R5: Queue two started at entry 63 converts once, then completes at the table end. A start index in 64..127 completes at once with no conversion.
- R6: A paused entry's conversion completes first. Then the pause flag is set and the status becomes paused (code 2), and the next trigger resumes at the following entry.
- R7: A paused entry followed by an end-of-queue condition sets both the pause and completion flags and leaves the status idle.
- R8: Pause and end of queue on the same entry: end of queue wins, no conversion is done and the pause flag stays clear.
- R9: Several end-of-queue conditions on one entry behave exactly like one.
- R10: A trigger after completion restarts the queue at its first entry.
- R11: Flags are sticky until a write-one-to-clear pulse, which clears only the addressed flag. Each interrupt equals its flag ANDed with its enable.
- R12: A trigger to a queue that is already active is ignored and is not remembered.
- R13: When both queues are triggered together, queue one runs first, and queue two stays pending until queue one stops and then runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 2 | Trigger pulses, bit 0 queue one, bit 1 queue two |
| q2_begin | input | IDX_W+1 | Queue two start index |
| ccw_addr | output | IDX_W | Command table read index |
| ccw_chan | input | CH_W | Channel field of addressed entry |
| ccw_pause | input | 1 | Pause bit of addressed entry |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | CH_W | Channel to convert |
| conv_done | input | 1 | One-cycle conversion finished pulse |
| pause_clr | input | 2 | Write-one-to-clear for pause flags |
| done_clr | input | 2 | Write-one-to-clear for completion flags |
| pause_ie | input | 2 | Pause interrupt enables |
| done_ie | input | 2 | Completion interrupt enables |
| pause_flag | output | 2 | Sticky pause flags |
| done_flag | output | 2 | Sticky completion flags |
| pause_irq | output | 2 | Pause interrupts |
| done_irq | output | 2 | Completion interrupts |
| q1_status | output | 2 | Queue one status: 0 idle, 1 active, 2 paused |
| q2_status | output | 2 | Queue two status, same encoding |

## Verification
The bench uses the default IDX_W of 6 and CH_W of 6. This gives a real 64-entry table, so the table-end boundary at entry 63, the start index range above 63, and the reserved code 63 can all be reached exactly. Queue runs of up to 40 conversions stay short, which lets each scenario check the full conversion count and the channel of the first conversion.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE   = 2'd0,
    QS_ACTIVE = 2'd1,
    QS_PAUSED = 2'd2
  } qstat_e;

  typedef enum logic [1:0] {
    SQ_WAIT = 2'd0,
    SQ_EVAL = 2'd1,
    SQ_CONV = 2'd2
  } seq_e;
endpackage

// File: rtl/qseq_eoq.sv
module qseq_eoq #(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6
) (
  input  logic [IDX_W:0]   ptr,
  input  logic [IDX_W:0]   q2_begin,
  input  logic [CH_W-1:0]  chan,
  input  logic             is_q1,
  output logic             eoq
);
  localparam logic [CH_W-1:0] EOQ_CODE = '1;

  logic past_table, code_hit, bound_hit;

  always_comb begin
    past_table = ptr[IDX_W];
    code_hit   = (chan == EOQ_CODE);
    bound_hit  = is_q1 && (ptr == q2_begin);
    eoq        = past_table || code_hit || bound_hit;
  end
endmodule

// File: rtl/qseq_flags.sv
module qseq_flags #(
  parameter int NQ = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] set_p,
  input  logic [NQ-1:0] set_c,
  input  logic [NQ-1:0] clr_p,
  input  logic [NQ-1:0] clr_c,
  input  logic [NQ-1:0] ie_p,
  input  logic [NQ-1:0] ie_c,
  output logic [NQ-1:0] flag_p,
  output logic [NQ-1:0] flag_c,
  output logic [NQ-1:0] irq_p,
  output logic [NQ-1:0] irq_c
);
  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic p_d, c_d, p_q, c_q;

    always_comb begin
      p_d = set_p[i] ? 1'b1 : (clr_p[i] ? 1'b0 : p_q);
      c_d = set_c[i] ? 1'b1 : (clr_c[i] ? 1'b0 : c_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_q <= 1'b0;
        c_q <= 1'b0;
      end else begin
        p_q <= p_d;
        c_q <= c_d;
      end
    end

    assign flag_p[i] = p_q;
    assign flag_c[i] = c_q;
    assign irq_p[i]  = p_q & ie_p[i];
    assign irq_c[i]  = c_q & ie_c[i];
  end
endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       trig,
  input  logic [IDX_W:0]   q2_begin,
  output logic [IDX_W-1:0] ccw_addr,
  input  logic [CH_W-1:0]  ccw_chan,
  input  logic             ccw_pause,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [1:0]       pause_clr,
  input  logic [1:0]       done_clr,
  input  logic [1:0]       pause_ie,
  input  logic [1:0]       done_ie,
  output logic [1:0]       pause_flag,
  output logic [1:0]       done_flag,
  output logic [1:0]       pause_irq,
  output logic [1:0]       done_irq,
  output logic [1:0]       q1_status,
  output logic [1:0]       q2_status
);
  localparam int NQ = 2;
  localparam int PW = IDX_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  seq_e            state_q, state_d;
  logic            sel_q, sel_d;
  logic [PW-1:0]   ptr_q, ptr_d;
  logic            hold_q, hold_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic            cpause_q, cpause_d;
  logic [NQ-1:0]   pend_q, pend_d;
  qstat_e          stat_q [NQ];
  qstat_e          stat_d [NQ];
  logic [PW-1:0]   resume_q [NQ];
  logic [PW-1:0]   resume_d [NQ];
  logic [NQ-1:0]   set_p, set_c, act_mask;
  logic            eoq;
  logic            k;

  qseq_eoq #(.IDX_W(IDX_W), .CH_W(CH_W)) u_eoq (
    .ptr      (ptr_q),
    .q2_begin (q2_begin),
    .chan     (ccw_chan),
    .is_q1    (!sel_q),
    .eoq      (eoq)
  );

  for (genvar i = 0; i < NQ; i++) begin : g_act
    assign act_mask[i] = (stat_q[i] == QS_ACTIVE);
  end

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    ptr_d    = ptr_q;
    hold_d   = hold_q;
    chan_d   = chan_q;
    cpause_d = cpause_q;
    pend_d   = pend_q | (trig & ~act_mask);
    set_p    = '0;
    set_c    = '0;
    k        = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      stat_d[i]   = stat_q[i];
      resume_d[i] = resume_q[i];
    end
    unique case (state_q)
      SQ_WAIT: begin
        if (pend_q != '0) begin
          k         = !pend_q[0];
          pend_d[k] = 1'b0;
          sel_d     = k;
          if (stat_q[k] == QS_PAUSED) ptr_d = resume_q[k];
          else if (k == 1'b0)         ptr_d = '0;
          else                        ptr_d = q2_begin;
          stat_d[k] = QS_ACTIVE;
          hold_d    = 1'b0;
          state_d   = SQ_EVAL;
        end
      end
      SQ_EVAL: begin
        if (eoq) begin
          set_c[sel_q]  = 1'b1;
          stat_d[sel_q] = QS_IDLE;
          state_d       = SQ_WAIT;
        end else if (hold_q) begin
          stat_d[sel_q]   = QS_PAUSED;
          resume_d[sel_q] = ptr_q;
          state_d         = SQ_WAIT;
        end else begin
          chan_d   = ccw_chan;
          cpause_d = ccw_pause;
          state_d  = SQ_CONV;
        end
      end
      SQ_CONV: begin
        if (conv_done) begin
          ptr_d   = ptr_q + 1'b1;
          hold_d  = cpause_q;
          set_p[sel_q] = cpause_q;
          state_d = SQ_EVAL;
        end
      end
      default: state_d = SQ_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= SQ_WAIT;
      sel_q    <= 1'b0;
      ptr_q    <= '0;
      hold_q   <= 1'b0;
      chan_q   <= '0;
      cpause_q <= 1'b0;
      pend_q   <= '0;
      for (int i = 0; i < NQ; i++) begin
        stat_q[i]   <= QS_IDLE;
        resume_q[i] <= '0;
      end
    end else begin
      state_q  <= state_d;
      sel_q    <= sel_d;
      ptr_q    <= ptr_d;
      hold_q   <= hold_d;
      chan_q   <= chan_d;
      cpause_q <= cpause_d;
      pend_q   <= pend_d;
      for (int i = 0; i < NQ; i++) begin
        stat_q[i]   <= stat_d[i];
        resume_q[i] <= resume_d[i];
      end
    end
  end

  qseq_flags #(.NQ(NQ)) u_flags (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .set_p  (set_p),
    .set_c  (set_c),
    .clr_p  (pause_clr),
    .clr_c  (done_clr),
    .ie_p   (pause_ie),
    .ie_c   (done_ie),
    .flag_p (pause_flag),
    .flag_c (done_flag),
    .irq_p  (pause_irq),
    .irq_c  (done_irq)
  );

  assign ccw_addr  = ptr_q[IDX_W-1:0];
  assign conv_req  = (state_q == SQ_CONV);
  assign conv_chan = chan_q;
  assign q1_status = stat_q[0];
  assign q2_status = stat_q[1];
endmodule

// File: rtl/qseq_chk.sv
module qseq_chk #(
  parameter int CH_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_req,
  input logic            conv_done,
  input logic [CH_W-1:0] conv_chan,
  input logic [1:0]      done_flag,
  input logic [1:0]      q1_status,
  input logic [1:0]      q2_status
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));

  // R3
  no_eoq_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_chan != {CH_W{1'b1}}));

  // R2
  req_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (q1_status == 2'd1 || q2_status == 2'd1));

  // R13
  single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q1_status == 2'd1 && q2_status == 2'd1));

  // R3
  q1_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag[0]) |-> (q1_status == 2'd0));

  // R5
  q2_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag[1]) |-> (q2_status == 2'd0));
endmodule

bind qseq_top qseq_chk #(.CH_W(CH_W)) u_qseq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_req  (conv_req),
  .conv_done (conv_done),
  .conv_chan (conv_chan),
  .done_flag (done_flag),
  .q1_status (q1_status),
  .q2_status (q2_status)
);

// File: tb/qseq_top_bench.sv
module qseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam int CH_W  = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       trig;
  logic [IDX_W:0]   q2_begin;
  logic [IDX_W-1:0] ccw_addr;
  logic [CH_W-1:0]  ccw_chan;
  logic             ccw_pause;
  logic             conv_req;
  logic [CH_W-1:0]  conv_chan;
  logic             conv_done;
  logic [1:0]       pause_clr, done_clr, pause_ie, done_ie;
  logic [1:0]       pause_flag, done_flag, pause_irq, done_irq;
  logic [1:0]       q1_status, q2_status;

  logic [CH_W-1:0]  tb_chan  [64];
  logic             tb_pause [64];

  int total = 0;
  int fails = 0;
  int conv_cnt = 0;
  int first_chan = -1;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ccw_chan  = tb_chan[ccw_addr];
  assign ccw_pause = tb_pause[ccw_addr];

  qseq_top #(.IDX_W(IDX_W), .CH_W(CH_W)) u_qseq_top (
    .clk(clk), .rst_n(rst_n), .trig(trig), .q2_begin(q2_begin),
    .ccw_addr(ccw_addr), .ccw_chan(ccw_chan), .ccw_pause(ccw_pause),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .pause_clr(pause_clr), .done_clr(done_clr), .pause_ie(pause_ie),
    .done_ie(done_ie), .pause_flag(pause_flag), .done_flag(done_flag),
    .pause_irq(pause_irq), .done_irq(done_irq),
    .q1_status(q1_status), .q2_status(q2_status)
  );

  // converter model: answers each request with a one-cycle done pulse
  initial begin
    conv_done = 1'b0;
    forever begin
      @(negedge clk);
      if (conv_req && !conv_done) begin
        conv_done = 1'b1;
        if (conv_cnt == 0) first_chan = int'(conv_chan);
        conv_cnt++;
      end else begin
        conv_done = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic default_table();
    for (int i = 0; i < 64; i++) begin
      tb_chan[i]  = CH_W'(i % 8);
      tb_pause[i] = 1'b0;
    end
    tb_chan[40] = '1;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    pause_clr = 2'b11;
    done_clr  = 2'b11;
    @(negedge clk);
    pause_clr = 2'b00;
    done_clr  = 2'b00;
  endtask

  function automatic logic [1:0] stat_of(input int q);
    return (q == 0) ? q1_status : q2_status;
  endfunction

  // pulse a trigger and wait for that queue to leave the active state
  task automatic run(input int q);
    conv_cnt   = 0;
    first_chan = -1;
    @(negedge clk);
    trig[q] = 1'b1;
    @(negedge clk);
    trig = 2'b00;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 5000 && stat_of(q) == 2'd1; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic       q;
    logic [6:0] bq;
    logic [7:0] ncv;
    logic [3:0] req;
  } vec_t;

  // default table: channel i%8, code 63 at entry 40
  localparam vec_t VECS [9] = '{
    '{1'b0, 7'd64,  8'd40, 4'd3},  // R3 code ends queue one
    '{1'b0, 7'd10,  8'd10, 4'd4},  // R4 boundary at start index
    '{1'b0, 7'd0,   8'd0,  4'd4},  // R4 start index zero
    '{1'b1, 7'd41,  8'd23, 4'd5},  // R5 runs to table end
    '{1'b1, 7'd63,  8'd1,  4'd5},  // R5 start at last entry
    '{1'b1, 7'd100, 8'd0,  4'd5},  // R5 start beyond table
    '{1'b1, 7'd40,  8'd0,  4'd3},  // R3 code in first entry
    '{1'b0, 7'd40,  8'd40, 4'd9},  // R9 code and boundary together
    '{1'b1, 7'd10,  8'd30, 4'd2}   // R2 queue two from index 10
  };

  initial begin
    rst_n = 1'b0; trig = '0; q2_begin = 7'd64;
    pause_clr = '0; done_clr = '0; pause_ie = '0; done_ie = '0;
    default_table();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 q1_status", int'(q1_status), 0);
    chk("R1 q2_status", int'(q2_status), 0);
    chk("R1 flags", int'({pause_flag, done_flag, pause_irq, done_irq}), 0);
    chk("R1 conv_req", int'(conv_req), 0);

    for (int v = 0; v < 9; v++) begin
      int q;
      q = int'(VECS[v].q);
      q2_begin = VECS[v].bq;
      run(q);
      chk($sformatf("R%0d vec%0d count", VECS[v].req, v), conv_cnt, int'(VECS[v].ncv));
      chk($sformatf("R%0d vec%0d status", VECS[v].req, v), int'(stat_of(q)), 0);
      chk($sformatf("R%0d vec%0d done flag", VECS[v].req, v), int'(done_flag[q]), 1);
      chk($sformatf("R%0d vec%0d pause flag", VECS[v].req, v), int'(pause_flag[q]), 0);
      if (VECS[v].ncv != 0)
        chk($sformatf("R2 vec%0d first channel", v), first_chan,
            (q == 0) ? 0 : int'(VECS[v].bq) % 8);
      clear_flags();
    end

    // R7 pause at 5, code 63 at 6; R11 interrupt gating and W1C
    q2_begin = 7'd64;
    pause_ie = 2'b01; done_ie = 2'b00;
    tb_pause[5] = 1'b1; tb_chan[6] = '1;
    run(0);
    chk("R7 count", conv_cnt, 6);
    chk("R7 status", int'(q1_status), 0);
    chk("R7 pause flag", int'(pause_flag[0]), 1);
    chk("R7 done flag", int'(done_flag[0]), 1);
    chk("R11 pause irq enabled", int'(pause_irq[0]), 1);
    chk("R11 done irq disabled", int'(done_irq[0]), 0);
    @(negedge clk); pause_clr = 2'b01; @(negedge clk); pause_clr = 2'b00;
    chk("R11 pause cleared", int'(pause_flag[0]), 0);
    chk("R11 done kept", int'(done_flag[0]), 1);
    done_ie = 2'b01;
    @(negedge clk);
    chk("R11 done irq enabled", int'(done_irq[0]), 1);
    pause_ie = '0; done_ie = '0;
    clear_flags();
    default_table();

    // R6 pause at entry 3, then resume
    tb_pause[3] = 1'b1;
    run(0);
    chk("R6 count", conv_cnt, 4);
    chk("R6 status paused", int'(q1_status), 2);
    chk("R6 pause flag", int'(pause_flag[0]), 1);
    chk("R6 done flag", int'(done_flag[0]), 0);
    run(0);
    chk("R6 resume count", conv_cnt, 36);
    chk("R6 resume first channel", first_chan, 4);
    chk("R6 resume status", int'(q1_status), 0);
    chk("R6 resume done flag", int'(done_flag[0]), 1);
    clear_flags();
    default_table();

    // R8 pause and code 63 on the same entry
    tb_pause[7] = 1'b1; tb_chan[7] = '1;
    run(0);
    chk("R8 count", conv_cnt, 7);
    chk("R8 pause flag", int'(pause_flag[0]), 0);
    chk("R8 done flag", int'(done_flag[0]), 1);
    clear_flags();
    default_table();

    // R7 pause on entry 63 in queue two
    tb_pause[63] = 1'b1; q2_begin = 7'd60;
    run(1);
    chk("R7 q2 count", conv_cnt, 4);
    chk("R7 q2 status", int'(q2_status), 0);
    chk("R7 q2 pause flag", int'(pause_flag[1]), 1);
    chk("R7 q2 done flag", int'(done_flag[1]), 1);
    clear_flags();
    default_table();

    // R10 restart after completion
    q2_begin = 7'd64;
    run(0);
    run(0);
    chk("R10 restart count", conv_cnt, 40);
    chk("R10 restart first channel", first_chan, 0);
    clear_flags();

    // R12 trigger while active is dropped
    conv_cnt = 0;
    @(negedge clk); trig = 2'b01; @(negedge clk); trig = 2'b00;
    repeat (10) @(negedge clk);
    trig = 2'b01; @(negedge clk); trig = 2'b00;
    for (int n = 0; n < 5000 && q1_status == 2'd1; n++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R12 count", conv_cnt, 40);
    chk("R12 status", int'(q1_status), 0);
    clear_flags();

    // R13 simultaneous triggers
    q2_begin = 7'd50;
    conv_cnt = 0; first_chan = -1;
    @(negedge clk); trig = 2'b11; @(negedge clk); trig = 2'b00;
    for (int n = 0; n < 5000 && done_flag[1] == 1'b0; n++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R13 first channel from queue one", first_chan, 0);
    chk("R13 total count", conv_cnt, 54);
    chk("R13 q1 done", int'(done_flag[0]), 1);
    chk("R13 q2 done", int'(done_flag[1]), 1);
    chk("R13 q2 status", int'(q2_status), 0);

    summary();
    $finish;
  end
endmodule